// File: doc/BRIEF.md
# Processor Run-Control and Breakpoint Unit

This unit sits next to a small 32-bit RISC core and gives a host debugger control over execution. The host issues one-cycle commands on a small command port: stop the core, let it run again, advance it by exactly one instruction, load a new program counter, set the single instruction breakpoint, or return the unit to its power-on state. The unit drives a run enable that the core uses to stall its pipeline. It drives a one-cycle PC-load strobe with a value, and it watches the core's fetch address and its instruction-retire pulse.

The control is a four-state machine. In `ST_RUN` the core runs freely; an enabled breakpoint match drops the run enable in the same cycle and moves to `ST_HALT`. A halt command also moves to `ST_HALT`. In `ST_HALT` the run enable is low. A step command moves to `ST_STEP` and an unhalt command moves to `ST_LEAVE`. `ST_STEP` holds the run enable high until the core retires one instruction, then returns to `ST_HALT`. `ST_LEAVE` also runs until the first retire, with breakpoint comparison suppressed so the core can move off a breakpoint address, then enters `ST_RUN`. A halt command in `ST_STEP` or `ST_LEAVE` goes to `ST_HALT`. A reset command from any state goes to `ST_RUN`.

Top module: `dbg_runctl`

## Requirements
- R1: Command code 1 (halt) moves the unit to halted at the next clock edge; while halted `stat_halted` is 1 and `core_run` is 0.
- R2: Command code 2 (unhalt) while halted makes `core_run` 1 and `stat_halted` 0 after the next edge; unhalt while running has no effect.
- R3: Command code 3 (step) while halted raises `core_run` after the next edge and holds it high through any number of cycles without a retire; the edge that samples `core_retire` high returns the unit to halted.
- R4: A step command while not halted is ignored: the core keeps running and the unit does not halt.
- R5: Command code 4 (PC write) while halted produces `pc_load_en` high for exactly one cycle after the next edge, with `pc_load_val` equal to the command data; while not halted it produces no strobe.
- R6: Command code 5 writes the breakpoint register `stat_bp_value`. A value with bit 0 set is the disable code: it never matches, even when the fetch address equals it.
- R7: While running, a fetch address equal to an enabled breakpoint drops `core_run` in that same cycle; after the next edge `stat_halted` and `stat_bp_hit` are 1.
- R8: After unhalt, breakpoint comparison is suppressed until the first retire, so the core leaves a breakpoint address; after that retire a match halts the core again.
- R9: `stat_bp_hit` clears on the edge that accepts an unhalt or a step command while halted.
- R10: Command code 6 (reset) returns the unit to its power-on state from any state: running, breakpoint 1, `stat_bp_hit` 0.
- R11: After `rst_n` is released the unit is running, with `stat_bp_value` equal to 1 (disabled), `stat_bp_hit` 0 and `pc_load_en` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Command strobe, one cycle per command |
| host_op | input | 3 | Command code (1 halt, 2 unhalt, 3 step, 4 PC write, 5 breakpoint write, 6 reset) |
| host_data | input | 32 | Data for PC and breakpoint writes |
| stat_halted | output | 1 | Unit is in the halted state |
| stat_bp_hit | output | 1 | Last stop came from the breakpoint |
| stat_bp_value | output | 32 | Current breakpoint register |
| core_run | output | 1 | Run enable to the core |
| core_retire | input | 1 | Core retired one instruction this cycle |
| fetch_addr | input | 32 | Core's current fetch address |
| pc_load_en | output | 1 | One-cycle PC-load strobe |
| pc_load_val | output | 32 | Value to load into the PC |

## Verification
Assertions check on every cycle that a halt command always yields a halted unit with the run enable low, and that a halted unit never enables the core. They also check that a PC-load strobe only follows a halted cycle, that a disabled breakpoint never raises the hit flag, that a rising hit flag always comes with the halted state, that a step to a running core never halts it, and that accepted unhalt or step commands clear the hit flag. Only the bench's scenarios can show the one-instruction step that waits on an arbitrary retire delay, and the suppressed comparison when leaving a breakpoint followed by a fresh match. They also show the exact PC-load value and its one-cycle width, and the full return to power-on values after the reset command.

// File: rtl/dbg_runctl_pkg.sv
package dbg_runctl_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_HALT   = 3'd1,
        OP_UNHALT = 3'd2,
        OP_STEP   = 3'd3,
        OP_PCWR   = 3'd4,
        OP_BPWR   = 3'd5,
        OP_RESET  = 3'd6
    } host_op_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HALT  = 2'd1,
        ST_STEP  = 2'd2,
        ST_LEAVE = 2'd3
    } run_state_e;

endpackage

// File: rtl/dbg_bp_match.sv
module dbg_bp_match #(
    parameter int          ADDR_W  = 32,
    parameter logic [31:0] BP_INIT = 32'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] bp_value,
    output logic              match
);
    localparam logic [ADDR_W-1:0] INIT_V = ADDR_W'(BP_INIT);

    logic [ADDR_W-1:0] bp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bp_q <= INIT_V;
        end else if (soft_rst) begin
            bp_q <= INIT_V;
        end else if (wr_en) begin
            bp_q <= wr_data;
        end
    end

    // bit 0 set is the disable code
    assign match    = !bp_q[0] && (fetch_addr == bp_q);
    assign bp_value = bp_q;
endmodule

// File: rtl/dbg_pc_loader.sv
module dbg_pc_loader #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              req,
    input  logic              halted,
    input  logic [ADDR_W-1:0] data,
    output logic              load_en,
    output logic [ADDR_W-1:0] load_val
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_en  <= 1'b0;
            load_val <= '0;
        end else if (soft_rst) begin
            load_en  <= 1'b0;
            load_val <= '0;
        end else begin
            load_en <= req && halted;
            if (req && halted) begin
                load_val <= data;
            end
        end
    end
endmodule

// File: rtl/dbg_run_fsm.sv
module dbg_run_fsm
    import dbg_runctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       do_reset,
    input  logic       do_halt,
    input  logic       do_unhalt,
    input  logic       do_step,
    input  logic       bp_match,
    input  logic       retire,
    output run_state_e state,
    output logic       run_en,
    output logic       bp_hit
);
    run_state_e state_q, state_d;
    logic       hit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (do_reset) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (do_halt || bp_match) state_d = ST_HALT;
                end
                ST_HALT: begin
                    if (do_step)        state_d = ST_STEP;
                    else if (do_unhalt) state_d = ST_LEAVE;
                end
                ST_STEP: begin
                    if (do_halt || retire) state_d = ST_HALT;
                end
                ST_LEAVE: begin
                    if (do_halt)     state_d = ST_HALT;
                    else if (retire) state_d = ST_RUN;
                end
                default: state_d = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else if (do_reset) begin
            hit_q <= 1'b0;
        end else if (state_q == ST_RUN && bp_match) begin
            hit_q <= 1'b1;
        end else if (state_q == ST_HALT && (do_step || do_unhalt)) begin
            hit_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:   run_en = !bp_match;
            ST_HALT:  run_en = 1'b0;
            ST_STEP:  run_en = 1'b1;
            ST_LEAVE: run_en = 1'b1;
            default:  run_en = 1'b0;
        endcase
    end

    assign state  = state_q;
    assign bp_hit = hit_q;
endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
    import dbg_runctl_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter logic [31:0] BP_INIT = 32'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic [2:0]        host_op,
    input  logic [ADDR_W-1:0] host_data,
    output logic              stat_halted,
    output logic              stat_bp_hit,
    output logic [ADDR_W-1:0] stat_bp_value,
    output logic              core_run,
    input  logic              core_retire,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              pc_load_en,
    output logic [ADDR_W-1:0] pc_load_val
);
    logic       do_reset, do_halt, do_unhalt, do_step, do_pcwr, do_bpwr;
    logic       raw_match, gated_match;
    run_state_e state;

    assign do_reset  = host_valid && (host_op == OP_RESET);
    assign do_halt   = host_valid && (host_op == OP_HALT);
    assign do_unhalt = host_valid && (host_op == OP_UNHALT);
    assign do_step   = host_valid && (host_op == OP_STEP);
    assign do_pcwr   = host_valid && (host_op == OP_PCWR);
    assign do_bpwr   = host_valid && (host_op == OP_BPWR);

    dbg_bp_match #(.ADDR_W(ADDR_W), .BP_INIT(BP_INIT)) u_bp (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (do_reset),
        .wr_en      (do_bpwr),
        .wr_data    (host_data),
        .fetch_addr (fetch_addr),
        .bp_value   (stat_bp_value),
        .match      (raw_match)
    );

    // comparison only counts while freely running
    assign gated_match = raw_match && (state == ST_RUN);

    dbg_run_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_reset  (do_reset),
        .do_halt   (do_halt),
        .do_unhalt (do_unhalt),
        .do_step   (do_step),
        .bp_match  (gated_match),
        .retire    (core_retire),
        .state     (state),
        .run_en    (core_run),
        .bp_hit    (stat_bp_hit)
    );

    assign stat_halted = (state == ST_HALT);

    dbg_pc_loader #(.ADDR_W(ADDR_W)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (do_reset),
        .req      (do_pcwr),
        .halted   (stat_halted),
        .data     (host_data),
        .load_en  (pc_load_en),
        .load_val (pc_load_val)
    );
endmodule

// File: rtl/dbg_runctl_chk.sv
module dbg_runctl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_valid,
    input logic [2:0]        host_op,
    input logic              stat_halted,
    input logic              stat_bp_hit,
    input logic [ADDR_W-1:0] stat_bp_value,
    input logic              core_run,
    input logic              core_retire,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              pc_load_en
);
    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_op == 3'd1) |=> (stat_halted && !core_run)); // R1

    AST_HALTED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_halted |-> !core_run); // R1

    AST_STEP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_op == 3'd3 && !stat_halted && core_run && !core_retire
         && !(fetch_addr == stat_bp_value && !stat_bp_value[0])) |=> !stat_halted); // R4

    AST_PC_LOAD_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_en |-> $past(stat_halted)); // R5

    AST_BP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_bp_value[0] && !stat_bp_hit) |=> !stat_bp_hit); // R6

    AST_BP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_bp_hit) |-> stat_halted); // R7

    AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_bp_hit && stat_halted && host_valid && (host_op == 3'd2 || host_op == 3'd3))
        |=> !stat_bp_hit); // R9
endmodule

bind dbg_runctl dbg_runctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_valid    (host_valid),
    .host_op       (host_op),
    .stat_halted   (stat_halted),
    .stat_bp_hit   (stat_bp_hit),
    .stat_bp_value (stat_bp_value),
    .core_run      (core_run),
    .core_retire   (core_retire),
    .fetch_addr    (fetch_addr),
    .pc_load_en    (pc_load_en)
);

// File: tb/dbg_runctl_tb.sv
`timescale 1ns/1ps
module dbg_runctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic [2:0]  host_op = 3'd0;
    logic [31:0] host_data = 32'd0;
    logic        stat_halted, stat_bp_hit, core_run, pc_load_en;
    logic [31:0] stat_bp_value, pc_load_val;
    logic        core_retire = 1'b0;
    logic [31:0] fetch_addr = 32'h1000;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dbg_runctl u_dut (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_op(host_op),
        .host_data(host_data), .stat_halted(stat_halted), .stat_bp_hit(stat_bp_hit),
        .stat_bp_value(stat_bp_value), .core_run(core_run), .core_retire(core_retire),
        .fetch_addr(fetch_addr), .pc_load_en(pc_load_en), .pc_load_val(pc_load_val)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(logic [2:0] op, logic [31:0] data);
        @(negedge clk);
        host_valid = 1'b1; host_op = op; host_data = data;
        @(negedge clk);
        host_valid = 1'b0; host_op = 3'd0; host_data = 32'd0;
    endtask

    task automatic retire_one();
        @(negedge clk);
        core_retire = 1'b1;
        @(negedge clk);
        core_retire = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11", "halted", {31'd0, stat_halted}, 32'd0);
        chk("R11", "run", {31'd0, core_run}, 32'd1);
        chk("R11", "bp", stat_bp_value, 32'd1);
        chk("R11", "hit", {31'd0, stat_bp_hit}, 32'd0);
        chk("R11", "pcload", {31'd0, pc_load_en}, 32'd0);
    endtask

    task automatic t_halt();
        issue(3'd1, 0);
        chk("R1", "halted", {31'd0, stat_halted}, 32'd1);
        chk("R1", "run", {31'd0, core_run}, 32'd0);
    endtask

    task automatic t_step();
        issue(3'd3, 0);
        chk("R3", "run in step", {31'd0, core_run}, 32'd1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R3", "run held", {31'd0, core_run}, 32'd1);
        end
        retire_one();
        chk("R3", "halted after retire", {31'd0, stat_halted}, 32'd1);
        chk("R3", "run after retire", {31'd0, core_run}, 32'd0);
    endtask

    task automatic t_pcwr();
        issue(3'd4, 32'h1234);
        chk("R5", "load en", {31'd0, pc_load_en}, 32'd1);
        chk("R5", "load val", pc_load_val, 32'h1234);
        @(negedge clk);
        chk("R5", "load en one cycle", {31'd0, pc_load_en}, 32'd0);
    endtask

    task automatic t_running_ignores();
        issue(3'd2, 0);
        chk("R2", "halted", {31'd0, stat_halted}, 32'd0);
        chk("R2", "run", {31'd0, core_run}, 32'd1);
        retire_one();
        issue(3'd2, 0);
        chk("R2", "second unhalt", {31'd0, stat_halted}, 32'd0);
        issue(3'd3, 0);
        chk("R4", "step ignored halted", {31'd0, stat_halted}, 32'd0);
        chk("R4", "step ignored run", {31'd0, core_run}, 32'd1);
        issue(3'd4, 32'hABCD);
        chk("R5", "no load while running", {31'd0, pc_load_en}, 32'd0);
    endtask

    task automatic t_bp_disabled();
        issue(3'd5, 32'h301);
        chk("R6", "bp value", stat_bp_value, 32'h301);
        fetch_addr = 32'h301;
        #1;
        chk("R6", "run", {31'd0, core_run}, 32'd1);
        @(negedge clk);
        @(negedge clk);
        chk("R6", "halted", {31'd0, stat_halted}, 32'd0);
        chk("R6", "hit", {31'd0, stat_bp_hit}, 32'd0);
    endtask

    task automatic t_bp_hit();
        issue(3'd5, 32'h400);
        fetch_addr = 32'h400;
        #1;
        chk("R7", "run drops same cycle", {31'd0, core_run}, 32'd0);
        @(negedge clk);
        chk("R7", "halted", {31'd0, stat_halted}, 32'd1);
        chk("R7", "hit", {31'd0, stat_bp_hit}, 32'd1);
    endtask

    task automatic t_resume();
        issue(3'd2, 0);
        chk("R9", "hit cleared by unhalt", {31'd0, stat_bp_hit}, 32'd0);
        chk("R8", "runs at bp", {31'd0, core_run}, 32'd1);
        @(negedge clk);
        chk("R8", "still runs", {31'd0, stat_halted}, 32'd0);
        core_retire = 1'b1;
        fetch_addr = 32'h404;
        @(negedge clk);
        core_retire = 1'b0;
        chk("R8", "past bp", {31'd0, core_run}, 32'd1);
        fetch_addr = 32'h400;
        #1;
        chk("R8", "rematch drops run", {31'd0, core_run}, 32'd0);
        @(negedge clk);
        chk("R8", "halted again", {31'd0, stat_halted}, 32'd1);
        chk("R8", "hit again", {31'd0, stat_bp_hit}, 32'd1);
    endtask

    task automatic t_step_clears();
        issue(3'd3, 0);
        chk("R9", "hit cleared by step", {31'd0, stat_bp_hit}, 32'd0);
        chk("R3", "step runs at bp", {31'd0, core_run}, 32'd1);
        retire_one();
        chk("R3", "halted after step", {31'd0, stat_halted}, 32'd1);
        chk("R9", "hit stays clear", {31'd0, stat_bp_hit}, 32'd0);
    endtask

    task automatic t_soft_reset();
        issue(3'd1, 0);
        issue(3'd6, 0);
        chk("R10", "halted", {31'd0, stat_halted}, 32'd0);
        chk("R10", "hit", {31'd0, stat_bp_hit}, 32'd0);
        chk("R10", "bp", stat_bp_value, 32'd1);
        chk("R10", "run at old bp", {31'd0, core_run}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_halt();
        t_step();
        t_pcwr();
        t_running_ignores();
        t_bp_disabled();
        t_bp_hit();
        t_resume();
        t_step_clears();
        t_soft_reset();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule